// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block generates several edge-aligned PWM waveforms from a single time base. One up-counter, one power-of-two prescaler and one period (modulo) value are common to every output. Each channel adds its own compare value, its own mode-select bits and a two-bit level field. The level field picks the output polarity, and its reserved codes switch the output off. Software reaches the block through a plain 32-bit register bus with address, write data, write strobe, read strobe and read data.

Period and compare values are double-buffered. While the counter is stopped, a written value becomes active in the next cycle. While the counter mode is nonzero, the value waits in a buffer and moves to the active register in the cycle where the counter wraps. Reading back a period or compare register returns the buffered value while a load is pending and the active value after the load. A change to a channel's level field reaches the pin in the next cycle, with no wait for a period boundary.

Top module: `pwm_tmr_top`

## Requirements
- R1: Offset 0x04 reads the channel count in bits [7:0] with all other bits zero. Offset 0x08 and any unmapped offset read zero.
- R2: Offset 0x10 holds the prescaler exponent in bits [2:0], the counter mode in bits [4:3] and a held center-select bit in bit 5, and it reads back as written. Only mode 2'b01 advances the counter. In any other mode the counter holds its value.
- R3: With mode 2'b01 and exponent p, the counter (read at 0x14) advances exactly once every 2^p clocks.
- R4: The counter counts from 0 up to the active modulo value. On the next tick after reaching that value it returns to 0, and this wrap is the period start.
- R5: While the mode is 2'b00, a write to the 16-bit modulo register (0x18) or to a channel value register (0x24 + 8·n) becomes active in the next cycle.
- R6: While the mode is nonzero, a modulo write is held in a buffer and becomes active at the next wrap. Until then the counter keeps using the old period. A read returns the written value at once.
- R7: Channel value writes follow the same buffering rule as R6, so the new duty takes effect at the next wrap.
- R8: The channel control register is at 0x20 + 8·n, with bit 7 the event flag, bit 5 mode-select B, bit 4 mode-select A and bits [3:2] the level field. With bit 5 set and level 2'b10, the pin is high while counter < active compare value and low otherwise.
- R9: With bit 5 set and level 2'b01, the pin is the complement of the R8 waveform.
- R10: With level 2'b00 or 2'b11, or with bit 5 clear, the pin is low. A control write changes the pin in the cycle after the write.
- R11: A compare value of 0 gives a pin that is constantly low under R8. A compare value above the modulo gives a pin that is constantly high.
- R12: A channel's event flag (bit 7 of its control register, also on `evt_flag_o[n]`) sets on the tick where the counter steps onto that channel's compare value. Writing 1 to bit 7 clears it. A set in the same cycle wins over the clear.
- R13: After reset every register, the counter, all pins and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_re | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 32 | Read data, zero when bus_re is low |
| pwm_o | output | NUM_CH | PWM pins |
| evt_flag_o | output | NUM_CH | Per-channel compare event flags |

## Verification
The checker assumes that at most one register is written per cycle and that the bus address is stable while a strobe is high. The bench drives every strobe for exactly one clock from the falling edge, so both assumptions hold. The checker also assumes that software does not rewrite the modulo register in the same cycle as a wrap. The bench issues its buffered modulo write early in a long period, far from any wrap. Channel count is taken to be small enough that every channel offset fits in the address width, and the default of four channels meets this.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  localparam int unsigned BUS_W = 32;

  // byte offsets whose positions software decodes
  localparam logic [7:0] OFS_PARAM  = 8'h04;
  localparam logic [7:0] OFS_GLOBAL = 8'h08;
  localparam logic [7:0] OFS_SC     = 8'h10;
  localparam logic [7:0] OFS_CNT    = 8'h14;
  localparam logic [7:0] OFS_MOD    = 8'h18;
  localparam int         CH_BASE    = 32;
  localparam int         CH_STRIDE  = 8;

  localparam logic [1:0] CMODE_STOP = 2'b00;
  localparam logic [1:0] CMODE_TICK = 2'b01;
  localparam logic [1:0] LVL_HIGH   = 2'b10;
  localparam logic [1:0] LVL_LOW    = 2'b01;

  typedef struct packed {
    logic       evt;
    logic       msel_b;
    logic       msel_a;
    logic [1:0] lvl;
  } ch_ctrl_t;

  function automatic int ch_ctrl_ofs(input int idx);
    return CH_BASE + idx * CH_STRIDE;
  endfunction

  function automatic int ch_val_ofs(input int idx);
    return CH_BASE + idx * CH_STRIDE + 4;
  endfunction

  // pin level from the control fields and the compare result
  function automatic logic pin_level(input ch_ctrl_t c, input logic below);
    if (!c.msel_b)            return 1'b0;
    else if (c.lvl == LVL_HIGH) return below;
    else if (c.lvl == LVL_LOW)  return !below;
    else                        return 1'b0;
  endfunction

  function automatic logic [7:0] ctrl_image(input ch_ctrl_t c);
    return {c.evt, 1'b0, c.msel_b, c.msel_a, c.lvl, 2'b00};
  endfunction

endpackage

// File: rtl/pwm_tmr_dbuf.sv
// Active/shadow register pair: direct write when unbuffered,
// otherwise staged and moved across on the load strobe.
module pwm_tmr_dbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         load,
  output logic [W-1:0] act,
  output logic [W-1:0] view,
  output logic         pend
);
  logic [W-1:0] act_q, shadow_q;
  logic         pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else if (wr) begin
      if (buffered) begin
        shadow_q <= wdata;
        pend_q   <= 1'b1;
      end else begin
        act_q    <= wdata;
        pend_q   <= 1'b0;
      end
    end else if (load && pend_q) begin
      act_q  <= shadow_q;
      pend_q <= 1'b0;
    end
  end

  assign act  = act_q;
  assign pend = pend_q;
  assign view = pend_q ? shadow_q : act_q;
endmodule

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  function automatic logic [DIV_W-1:0] div_limit(input logic [PS_W-1:0] e);
    logic [DIV_W-1:0] ones;
    ones = '1;
    return ~(ones << e);
  endfunction

  logic [DIV_W-1:0] pre_q;

  assign tick = run && (pre_q == div_limit(ps));

  always_ff @(posedge clk) begin
    if (!rst_n)              pre_q <= '0;
    else if (!run || tick)   pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             buffered,
  input  logic             mod_wr,
  input  logic [CNT_W-1:0] mod_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap,
  output logic [CNT_W-1:0] mod_view,
  output logic             mod_pend
);
  logic [CNT_W-1:0] cnt_q, mod_act;

  pwm_tmr_dbuf #(.W(CNT_W)) mod_buf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (mod_wr),
    .wdata    (mod_wdata),
    .buffered (buffered),
    .load     (wrap),
    .act      (mod_act),
    .view     (mod_view),
    .pend     (mod_pend)
  );

  assign wrap    = tick && (cnt_q >= mod_act);
  assign cnt_nxt = !tick ? cnt_q : (wrap ? '0 : cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic             buffered,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  output logic             pwm,
  output logic             evt,
  output logic             match,
  output logic [CNT_W-1:0] val_view,
  output logic [7:0]       ctrl_view
);
  logic [CNT_W-1:0] val_act;
  logic             val_pend_unused;
  ch_ctrl_t         ctrl_q;
  logic             unused_ctrl_bits;

  assign unused_ctrl_bits = ^{ctrl_wdata[6], ctrl_wdata[1:0], val_pend_unused};

  pwm_tmr_dbuf #(.W(CNT_W)) val_buf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (val_wr),
    .wdata    (val_wdata),
    .buffered (buffered),
    .load     (wrap),
    .act      (val_act),
    .view     (val_view),
    .pend     (val_pend_unused)
  );

  // counter steps onto the compare value on this tick
  assign match = tick && (cnt_nxt == val_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.msel_b <= ctrl_wdata[5];
        ctrl_q.msel_a <= ctrl_wdata[4];
        ctrl_q.lvl    <= ctrl_wdata[3:2];
      end
      if (match)                        ctrl_q.evt <= 1'b1;
      else if (ctrl_wr && ctrl_wdata[7]) ctrl_q.evt <= 1'b0;
    end
  end

  assign pwm       = pin_level(ctrl_q, cnt < val_act);
  assign evt       = ctrl_q.evt;
  assign ctrl_view = ctrl_image(ctrl_q);
endmodule

// File: rtl/pwm_tmr_top.sv
module pwm_tmr_top
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] evt_flag_o
);
  logic [PS_W-1:0]  ps_q;
  logic [1:0]       mode_q;
  logic             cpwm_q;
  logic             run, buffered, tick, wrap, mod_pend, mod_wr, sc_wr;
  logic [CNT_W-1:0] cnt, cnt_nxt, mod_view;

  logic [NUM_CH-1:0]   ch_ctrl_wr, ch_val_wr, ch_match, flag_clr, ch_mb;
  logic [2*NUM_CH-1:0] ch_lvl;
  logic [CNT_W-1:0]    ch_val_view  [NUM_CH];
  logic [7:0]          ch_ctrl_view [NUM_CH];
  logic [31:0]         rd_mux;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign sc_wr    = bus_we && (bus_addr == ADDR_W'(OFS_SC));
  assign mod_wr   = bus_we && (bus_addr == ADDR_W'(OFS_MOD));
  assign run      = (mode_q == CMODE_TICK);
  assign buffered = (mode_q != CMODE_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q   <= '0;
      mode_q <= CMODE_STOP;
      cpwm_q <= 1'b0;
    end else if (sc_wr) begin
      ps_q   <= bus_wdata[PS_W-1:0];
      mode_q <= bus_wdata[PS_W+1:PS_W];
      cpwm_q <= bus_wdata[PS_W+2];
    end
  end

  pwm_tmr_prescale #(.PS_W(PS_W)) pre_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .ps    (ps_q),
    .tick  (tick)
  );

  pwm_tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .buffered  (buffered),
    .mod_wr    (mod_wr),
    .mod_wdata (bus_wdata[CNT_W-1:0]),
    .cnt       (cnt),
    .cnt_nxt   (cnt_nxt),
    .wrap      (wrap),
    .mod_view  (mod_view),
    .mod_pend  (mod_pend)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_ctrl_wr[i] = bus_we && (bus_addr == ADDR_W'(ch_ctrl_ofs(i)));
    assign ch_val_wr[i]  = bus_we && (bus_addr == ADDR_W'(ch_val_ofs(i)));
    assign flag_clr[i]   = ch_ctrl_wr[i] && bus_wdata[7];

    pwm_tmr_channel #(.CNT_W(CNT_W)) ch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .wrap       (wrap),
      .buffered   (buffered),
      .cnt        (cnt),
      .cnt_nxt    (cnt_nxt),
      .val_wr     (ch_val_wr[i]),
      .val_wdata  (bus_wdata[CNT_W-1:0]),
      .ctrl_wr    (ch_ctrl_wr[i]),
      .ctrl_wdata (bus_wdata[7:0]),
      .pwm        (pwm_o[i]),
      .evt        (evt_flag_o[i]),
      .match      (ch_match[i]),
      .val_view   (ch_val_view[i]),
      .ctrl_view  (ch_ctrl_view[i])
    );

    assign ch_mb[i]        = ch_ctrl_view[i][5];
    assign ch_lvl[2*i +: 2] = ch_ctrl_view[i][3:2];
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_PARAM))   rd_mux = 32'(NUM_CH);
    else if (bus_addr == ADDR_W'(OFS_SC))  rd_mux = 32'({cpwm_q, mode_q, ps_q});
    else if (bus_addr == ADDR_W'(OFS_CNT)) rd_mux = 32'(cnt);
    else if (bus_addr == ADDR_W'(OFS_MOD)) rd_mux = 32'(mod_view);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(ch_ctrl_ofs(i))) rd_mux = 32'(ch_ctrl_view[i]);
      if (bus_addr == ADDR_W'(ch_val_ofs(i)))  rd_mux = 32'(ch_val_view[i]);
    end
  end

  assign bus_rdata = bus_re ? rd_mux : '0;
endmodule

// File: rtl/pwm_tmr_sva.sv
module pwm_tmr_sva #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              buffered,
  input logic              tick,
  input logic              wrap,
  input logic [CNT_W-1:0]  cnt,
  input logic              mod_wr,
  input logic              mod_pend,
  input logic [NUM_CH-1:0] ch_match,
  input logic [NUM_CH-1:0] flag_clr,
  input logic [NUM_CH-1:0] ch_mb,
  input logic [2*NUM_CH-1:0] ch_lvl,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] evt_flag_o
);
  p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  p_mod_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mod_pend && !mod_wr) |=> !mod_pend);

  p_mod_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_wr && !buffered) |=> !mod_pend);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_mb[i] || ch_lvl[2*i +: 2] == 2'b00 || ch_lvl[2*i +: 2] == 2'b11)
        |-> !pwm_o[i]);

    p_flag_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ch_match[i] |=> evt_flag_o[i]);

    p_flag_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !ch_match[i]) |=> !evt_flag_o[i]);
  end
endmodule

bind pwm_tmr_top pwm_tmr_sva #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .buffered   (buffered),
  .tick       (tick),
  .wrap       (wrap),
  .cnt        (cnt),
  .mod_wr     (mod_wr),
  .mod_pend   (mod_pend),
  .ch_match   (ch_match),
  .flag_clr   (flag_clr),
  .ch_mb      (ch_mb),
  .ch_lvl     (ch_lvl),
  .pwm_o      (pwm_o),
  .evt_flag_o (evt_flag_o)
);

// File: tb/pwm_tmr_top_tb.sv
module pwm_tmr_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic [31:0] wd;
  logic        we, re;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm, evt;

  int n_tests = 0;
  int n_fail  = 0;
  bit checking = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_tmr_top #(.NUM_CH(NCH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (addr),
    .bus_wdata  (wd),
    .bus_we     (we),
    .bus_re     (re),
    .bus_rdata  (rdata),
    .pwm_o      (pwm),
    .evt_flag_o (evt)
  );

  // ---------------- behavioural reference model ----------------
  int m_ps, m_mode, m_cpwm, m_pre, m_cnt, m_mod_act, m_mod_buf;
  bit m_mod_pend;
  int m_val_act [NCH];
  int m_val_buf [NCH];
  bit m_val_pend[NCH];
  int m_ctrl    [NCH];
  bit m_evt     [NCH];
  bit m_run, m_tk, m_wrp, m_buffered, m_mt, m_clr;
  int m_ncnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ps = 0; m_mode = 0; m_cpwm = 0; m_pre = 0; m_cnt = 0;
      m_mod_act = 0; m_mod_buf = 0; m_mod_pend = 0;
      for (int c = 0; c < NCH; c++) begin
        m_val_act[c] = 0; m_val_buf[c] = 0; m_val_pend[c] = 0;
        m_ctrl[c] = 0; m_evt[c] = 0;
      end
    end else begin
      m_run      = (m_mode == 1);
      m_buffered = (m_mode != 0);
      m_tk       = m_run && (m_pre == (1 << m_ps) - 1);
      m_wrp      = m_tk && (m_cnt >= m_mod_act);
      m_ncnt     = !m_tk ? m_cnt : (m_wrp ? 0 : m_cnt + 1);
      for (int c = 0; c < NCH; c++) begin
        m_mt  = m_tk && (m_ncnt == m_val_act[c]);
        m_clr = we && (addr == 32 + 8*c) && wd[7];
        if (m_mt) m_evt[c] = 1;
        else if (m_clr) m_evt[c] = 0;
        if (we && addr == 36 + 8*c) begin
          if (m_buffered) begin m_val_buf[c] = wd & 32'hFFFF; m_val_pend[c] = 1; end
          else begin m_val_act[c] = wd & 32'hFFFF; m_val_pend[c] = 0; end
        end else if (m_wrp && m_val_pend[c]) begin
          m_val_act[c] = m_val_buf[c]; m_val_pend[c] = 0;
        end
        if (we && addr == 32 + 8*c) m_ctrl[c] = (wd >> 2) & 15;
      end
      if (we && addr == 8'h18) begin
        if (m_buffered) begin m_mod_buf = wd & 32'hFFFF; m_mod_pend = 1; end
        else begin m_mod_act = wd & 32'hFFFF; m_mod_pend = 0; end
      end else if (m_wrp && m_mod_pend) begin
        m_mod_act = m_mod_buf; m_mod_pend = 0;
      end
      if (we && addr == 8'h10) begin
        m_ps = wd & 7; m_mode = (wd >> 3) & 3; m_cpwm = (wd >> 5) & 1;
      end
      m_pre = (!m_run || m_tk) ? 0 : m_pre + 1;
      m_cnt = m_ncnt;
    end
  end

  function automatic bit m_pin(int c);
    int lvl;
    bit below;
    lvl   = m_ctrl[c] & 3;
    below = (m_cnt < m_val_act[c]);
    if (((m_ctrl[c] >> 3) & 1) == 0) return 0;
    if (lvl == 2) return below;
    if (lvl == 1) return !below;
    return 0;
  endfunction

  function automatic int m_read(int a);
    if (a == 4)  return NCH;
    if (a == 16) return m_ps | (m_mode << 3) | (m_cpwm << 5);
    if (a == 20) return m_cnt;
    if (a == 24) return m_mod_pend ? m_mod_buf : m_mod_act;
    for (int c = 0; c < NCH; c++) begin
      if (a == 32 + 8*c) return (int'(m_evt[c]) << 7) | (m_ctrl[c] << 2);
      if (a == 36 + 8*c) return m_val_pend[c] ? m_val_buf[c] : m_val_act[c];
    end
    return 0;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input string tag, input longint got, input longint exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // compare pins and flags against the model every cycle
  always @(negedge clk) begin
    if (rst_n && checking) begin
      for (int c = 0; c < NCH; c++) begin
        check($sformatf("R8 R9 R10 R11 pin ch%0d", c), pwm[c], m_pin(c));
        check($sformatf("R12 flag ch%0d", c), evt[c], m_evt[c]);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1;
    v = int'(rdata);
    re = 1'b0;
  endtask

  task automatic rdc(input logic [7:0] a, input string tag);
    int v;
    rd(a, v);
    check(tag, v, m_read(int'(a)));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int v, c0, c1;
    rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checking = 1;

    // R13 / R1: reset state and identification
    rd(8'h04, v); check("R1 channel count", v, NCH);
    rd(8'h08, v); check("R1 global reads zero", v, 0);
    rd(8'h7C, v); check("R1 unmapped reads zero", v, 0);
    rd(8'h10, v); check("R13 control reset", v, 0);
    rd(8'h14, v); check("R13 counter reset", v, 0);
    rd(8'h18, v); check("R13 modulo reset", v, 0);
    rd(8'h20, v); check("R13 channel ctrl reset", v, 0);
    check("R13 pins low", pwm, 0);

    // R5: direct loads while stopped
    wr(8'h18, 9);
    rd(8'h18, v); check("R5 modulo direct", v, 9);
    wr(8'h24, 4);  wr(8'h20, 32'h28);   // ch0 normal, duty 4
    wr(8'h2C, 4);  wr(8'h28, 32'h24);   // ch1 inverted
    wr(8'h34, 0);  wr(8'h30, 32'h28);   // ch2 zero duty
    wr(8'h3C, 20); wr(8'h38, 32'h28);   // ch3 compare above modulo
    rd(8'h20, v); check("R8 ctrl readback", v, 32'h28);
    rdc(8'h24, "R5 value direct");

    // R2 / R4: start counting, divide by one
    wr(8'h10, 32'h28 | 32'h08);
    rd(8'h10, v); check("R2 control readback", v, 32'h28);
    wr(8'h10, 32'h08);
    idle(30);
    check("R11 zero duty pin", pwm[2], 0);
    check("R11 full duty pin", pwm[3], 1);
    rdc(8'h14, "R4 counter tracks");
    check("R12 flag set", evt[0], 1);

    // R2 / R12: stop, counter holds, clear flag
    wr(8'h10, 0);
    rd(8'h14, c0); idle(10); rd(8'h14, c1);
    check("R2 counter holds when stopped", c1, c0);
    wr(8'h20, 32'hA8);
    check("R12 flag cleared", evt[0], 0);

    // R3: prescale by four
    wr(8'h18, 200);
    wr(8'h10, 32'h0A);
    rd(8'h14, c0); idle(63); rd(8'h14, c1);
    check("R3 sixteen ticks in 64 clocks", c1, c0 + 16);

    // R6: buffered modulo write
    wr(8'h18, 5);
    rd(8'h18, v); check("R6 modulo read returns written", v, 5);
    rd(8'h14, v); check("R6 old period still used", (v > 5) ? 1 : 0, 1);
    idle(900);
    for (int k = 0; k < 16; k++) begin
      rd(8'h14, v); check("R6 new period active", (v <= 5) ? 1 : 0, 1);
    end

    // R7: buffered compare write
    wr(8'h2C, 2);
    rd(8'h2C, v); check("R7 value read returns written", v, 2);
    idle(40);
    rdc(8'h2C, "R7 value after load");

    // R8 / R9: stop and inspect pins at a known count
    wr(8'h10, 0);
    rd(8'h14, c0);
    check("R8 normal pin", pwm[0], (c0 < 4) ? 1 : 0);
    check("R9 inverted pin", pwm[1], (c0 < 2) ? 0 : 1);

    // R10: reserved codes and mode-select B clear
    wr(8'h10, 32'h08);
    idle(7);
    wr(8'h20, 32'h2C);
    check("R10 level 11 low", pwm[0], 0);
    wr(8'h28, 32'h04);
    check("R10 select B clear low", pwm[1], 0);
    wr(8'h30, 32'h20);
    check("R10 level 00 low", pwm[2], 0);
    idle(20);

    // R5 again: modulo change while stopped, then run
    wr(8'h10, 0);
    wr(8'h18, 3);
    rdc(8'h18, "R5 modulo direct second");
    wr(8'h20, 32'h28);
    wr(8'h10, 32'h08);
    idle(40);
    rdc(8'h14, "R4 short period count");
    rdc(8'h20, "R12 flag via register");

    checking = 0;
    summary();
  end
endmodule